// File: doc/BRIEF.md
# Low-Power Mode Control Register and Sequencer

This block holds a small 8-bit control register and a three-state mode sequencer for a processor's low-power states. Software writes the register through a simple write strobe and data bus and reads it back on a read data bus. One bit selects which low-power state the CPU enters when it executes its sleep instruction. Another bit selects whether the I/O pins float while the deepest state is active.

The CPU signals the sleep instruction with a one-cycle pulse. The sequencer then moves from run to either light sleep or software standby, depending on the select bit. A single abstract wake event brings it back to run. While an external watchdog reports that it is running, the block refuses writes that would set either control bit. This stops software from entering standby, or floating the pins, with a live watchdog. Clearing a bit is always accepted.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), reg_rdata is 8'h00, mode is 2'b00 (run) and pin_hiz is 0.
- R2: With wdt_run at 0, a write (reg_wr high at an edge) loads reg_wdata[7] into the standby-select bit and reg_wdata[6] into the pin-float bit. Both appear on reg_rdata[7] and reg_rdata[6] after that edge.
- R3: While wdt_run is 1, a write with reg_wdata[7]=1 leaves the standby-select bit (reg_rdata[7]) at its previous value.
- R4: While wdt_run is 1, a write with reg_wdata[6]=1 leaves the pin-float bit (reg_rdata[6]) at its previous value.
- R5: A write with a 0 in bit 7 or bit 6 clears that bit, whatever the value of wdt_run.
- R6: reg_rdata[5:0] always reads 0, whatever has been written.
- R7: In run mode, a sleep_exec pulse with the standby-select bit at 0 gives mode 2'b01 (sleep) after that edge.
- R8: In run mode, a sleep_exec pulse with the standby-select bit at 1 gives mode 2'b10 (software standby) after that edge.
- R9: pin_hiz equals the pin-float bit while mode is 2'b10. It is 0 in run and sleep modes.
- R10: In sleep or standby, wake_evt at an edge returns mode to 2'b00 after that edge, and pin_hiz drops at the same time.
- R11: In sleep or standby, a sleep_exec pulse without wake_evt leaves mode unchanged.
- R12: In run mode, wake_evt without sleep_exec leaves mode at 2'b00. Mode never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (current contents) |
| sleep_exec | input | 1 | One-cycle pulse: the CPU executed its sleep instruction |
| wdt_run | input | 1 | High while the watchdog timer is running |
| wake_evt | input | 1 | Wake-up event |
| mode | output | 2 | Power mode: 00 run, 01 sleep, 10 software standby |
| pin_hiz | output | 1 | Drive I/O pins to high impedance |

## Verification
Every result is due one clock after its stimulus. A write, sleep pulse or wake event sampled at an edge shows on reg_rdata and mode just after that same edge, because only one register stage lies in each path. pin_hiz is decoded without a further register from the mode state and the pin-float bit, so it changes in the same cycle as mode. The bench drives inputs on the falling edge and updates its own model at the rising edge. It compares all three outputs 2 ns after that edge, before the next stimulus is applied.

// File: rtl/pwr_mode_pkg.sv
// Package: shared power-mode encoding and register layout defaults.
// Assumes the mode code is decoded elsewhere as 2 bits with 2'b11 unused.
package pwr_mode_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_SLEEP = 2'b01,
        PM_SSTBY = 2'b10
    } pm_mode_e;

    localparam int PM_REG_W    = 8;
    localparam int PM_STBY_POS = 7;
    localparam int PM_HIZ_POS  = 6;
endpackage

// File: rtl/pwr_ctl_reg.sv
// Control register holding the standby-select and pin-float bits.
// Setting a bit to 1 is refused while the watchdog runs; clearing is always
// accepted. All other bit positions read as zero and ignore writes.
// Assumes wdt_run is synchronous to clk.
module pwr_ctl_reg #(
    parameter int DW       = pwr_mode_pkg::PM_REG_W,
    parameter int STBY_POS = pwr_mode_pkg::PM_STBY_POS,
    parameter int HIZ_POS  = pwr_mode_pkg::PM_HIZ_POS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          wdt_run,
    output logic          stby_sel,
    output logic          hiz_sel,
    output logic [DW-1:0] rdata
);
    localparam int NBITS = 2;

    logic [NBITS-1:0] bit_q;

    // One guarded flop per implemented bit.
    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        localparam int POS = (g == 0) ? STBY_POS : HIZ_POS;

        // Load on write; a 1 is accepted only while the watchdog is stopped.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q[g] <= 1'b0;
            end else if (wr_en) begin
                if (!wdata[POS])
                    bit_q[g] <= 1'b0;
                else if (!wdt_run)
                    bit_q[g] <= 1'b1;
            end
        end
    end

    assign stby_sel = bit_q[0];
    assign hiz_sel  = bit_q[1];

    // Assemble the read word with unimplemented bits at zero.
    always_comb begin
        rdata           = '0;
        rdata[STBY_POS] = bit_q[0];
        rdata[HIZ_POS]  = bit_q[1];
    end
endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode sequencer: run -> sleep or standby on a sleep pulse, back to run on
// a wake event. Sleep pulses in a low-power state are ignored.
// Assumes sleep_exec is a single-cycle pulse from the CPU.
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep_exec,
    input  logic     wake_evt,
    input  logic     stby_sel,
    output pm_mode_e mode_q
);
    // Advance the power state once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_RUN;
        end else begin
            case (mode_q)
                PM_RUN: begin
                    if (sleep_exec)
                        mode_q <= stby_sel ? PM_SSTBY : PM_SLEEP;
                end
                PM_SLEEP, PM_SSTBY: begin
                    if (wake_evt)
                        mode_q <= PM_RUN;
                end
                default: mode_q <= PM_RUN;
            endcase
        end
    end
endmodule

// File: rtl/pwr_pin_ctl.sv
// Pin-float decode: the float request reaches the pins only in software
// standby. Purely combinational, so it follows the mode register directly.
module pwr_pin_ctl
    import pwr_mode_pkg::*;
(
    input  pm_mode_e mode_q,
    input  logic     hiz_sel,
    output logic     pin_hiz
);
    // Gate the float bit with the standby state.
    always_comb begin
        pin_hiz = (mode_q == PM_SSTBY) && hiz_sel;
    end
endmodule

// File: rtl/pwr_mode_ctl.sv
// Top level: control register, mode sequencer and pin-float decode.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module pwr_mode_ctl
    import pwr_mode_pkg::*;
#(
    parameter int DW = PM_REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sleep_exec,
    input  logic          wdt_run,
    input  logic          wake_evt,
    output logic [1:0]    mode,
    output logic          pin_hiz
);
    logic     stby_sel;
    logic     hiz_sel;
    pm_mode_e mode_q;

    pwr_ctl_reg #(
        .DW      (DW),
        .STBY_POS(PM_STBY_POS),
        .HIZ_POS (PM_HIZ_POS)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wdata   (reg_wdata),
        .wdt_run (wdt_run),
        .stby_sel(stby_sel),
        .hiz_sel (hiz_sel),
        .rdata   (reg_rdata)
    );

    pwr_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_exec(sleep_exec),
        .wake_evt  (wake_evt),
        .stby_sel  (stby_sel),
        .mode_q    (mode_q)
    );

    pwr_pin_ctl u_pin (
        .mode_q (mode_q),
        .hiz_sel(hiz_sel),
        .pin_hiz(pin_hiz)
    );

    assign mode = mode_q;
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
// Checker for pwr_mode_ctl, attached by bind. It observes only the ports.
module pwr_mode_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       sleep_exec,
    input logic       wdt_run,
    input logic       wake_evt,
    input logic [1:0] mode,
    input logic       pin_hiz
);
    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !wdt_run) |=> (reg_rdata[7:6] == $past(reg_wdata[7:6])));

    assert_stby_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wdt_run && reg_wdata[7]) |=> $stable(reg_rdata[7]));

    assert_hiz_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wdt_run && reg_wdata[6]) |=> $stable(reg_rdata[6]));

    assert_clear_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[7]) |=> !reg_rdata[7]);

    assert_low_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5:0] == 6'd0);

    assert_enter_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && sleep_exec && !reg_rdata[7]) |=> (mode == 2'b01));

    assert_enter_stby_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && sleep_exec && reg_rdata[7]) |=> (mode == 2'b10));

    assert_hiz_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hiz == ((mode == 2'b10) && reg_rdata[6]));

    assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && wake_evt) |=> (mode == 2'b00 && !pin_hiz));

    assert_sleep_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && !wake_evt) |=> $stable(mode));

    assert_run_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !sleep_exec) |=> (mode == 2'b00));

    assert_mode_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sleep_exec(sleep_exec),
    .wdt_run   (wdt_run),
    .wake_evt  (wake_evt),
    .mode      (mode),
    .pin_hiz   (pin_hiz)
);

// File: tb/test_pwr_mode_ctl.sv
// Bench for pwr_mode_ctl: directed corner cases followed by seeded random
// stimulus, compared against a behavioural model kept in bench functions.
module test_pwr_mode_ctl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       sleep_exec;
    logic       wdt_run;
    logic       wake_evt;
    logic [1:0] mode;
    logic       pin_hiz;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    logic [1:0] m_bits;   // [1] standby select, [0] pin float
    logic [1:0] m_mode;

    always #5 clk = ~clk;

    pwr_mode_ctl i_pwr_mode_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sleep_exec(sleep_exec),
        .wdt_run   (wdt_run),
        .wake_evt  (wake_evt),
        .mode      (mode),
        .pin_hiz   (pin_hiz)
    );

    function automatic logic f_bit_next(logic old, logic wr, logic d, logic wdt);
        if (!wr) return old;
        if (!d) return 1'b0;
        return wdt ? old : 1'b1;
    endfunction

    function automatic logic [1:0] f_mode_next(logic [1:0] m, logic slp, logic wk, logic stby);
        if (m == 2'b00) return slp ? (stby ? 2'b10 : 2'b01) : 2'b00;
        return wk ? 2'b00 : m;
    endfunction

    function automatic logic f_hiz(logic [1:0] m, logic fl);
        return (m == 2'b10) && fl;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, then compare.
    task automatic step(logic wr, logic [7:0] d, logic slp, logic wdt, logic wk,
                        string rq_reg, string rq_mode, string rq_hiz);
        @(negedge clk);
        reg_wr = wr; reg_wdata = d; sleep_exec = slp; wdt_run = wdt; wake_evt = wk;
        @(posedge clk);
        m_mode = f_mode_next(m_mode, slp, wk, m_bits[1]);
        m_bits = {f_bit_next(m_bits[1], wr, d[7], wdt), f_bit_next(m_bits[0], wr, d[6], wdt)};
        #2;
        check(rq_reg,  reg_rdata, {m_bits, 6'd0});
        check(rq_mode, {6'd0, mode}, {6'd0, m_mode});
        check(rq_hiz,  {7'd0, pin_hiz}, {7'd0, f_hiz(m_mode, m_bits[0])});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0000_5a17));
        rst_n = 1'b0; reg_wr = 0; reg_wdata = 8'h00; sleep_exec = 0; wdt_run = 0; wake_evt = 0;
        // Dirty the state before reset, then check reset clears it (R1).
        @(negedge clk); rst_n = 1'b1; reg_wr = 1; reg_wdata = 8'hFF;
        @(negedge clk); reg_wr = 0; sleep_exec = 1;
        @(negedge clk); sleep_exec = 0; rst_n = 1'b0;
        @(posedge clk); #2;
        m_bits = 2'b00; m_mode = 2'b00;
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 mode", {6'd0, mode}, 8'h00);
        check("R1 pin_hiz", {7'd0, pin_hiz}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // Sets refused while the watchdog runs (R3, R4); low bits stay zero (R6).
        step(1, 8'hFF, 0, 1, 0, "R3 R4 R6 guarded set", "R12 run holds", "R9 run");
        // Sets accepted with watchdog stopped (R2).
        step(1, 8'hC0, 0, 0, 0, "R2 load", "R12 run holds", "R9 run");
        // Set again with watchdog running keeps existing 1s (R3, R4).
        step(1, 8'hFF, 0, 1, 0, "R3 R4 keep", "R12", "R9");
        // Wake in run does nothing (R12).
        step(0, 8'h00, 0, 0, 1, "R2 hold", "R12 wake in run", "R9");
        // Sleep with standby selected enters standby, pins float (R8, R9).
        step(0, 8'h00, 1, 0, 0, "R2 hold", "R8 enter standby", "R9 float");
        // Sleep pulse in standby ignored (R11).
        step(0, 8'h00, 1, 0, 0, "R2 hold", "R11 ignored", "R9 float");
        // Wake releases mode and pins together (R10).
        step(0, 8'h00, 0, 0, 1, "R2 hold", "R10 wake", "R10 release");
        // Clear both while watchdog runs (R5).
        step(1, 8'h00, 0, 1, 0, "R5 clear", "R12", "R9");
        // Sleep with standby clear enters sleep (R7).
        step(0, 8'h00, 1, 0, 0, "R5 hold", "R7 enter sleep", "R9 sleep");
        step(0, 8'h00, 1, 0, 0, "R6", "R11 ignored in sleep", "R9 sleep");
        step(0, 8'h00, 0, 0, 1, "R6", "R10 wake sleep", "R9 run");
        // Standby without pin float keeps pins driven (R9).
        step(1, 8'h80, 0, 0, 0, "R2 stby only", "R12", "R9");
        step(0, 8'h00, 1, 0, 0, "R6", "R8 standby", "R9 no float");
        step(0, 8'h00, 0, 0, 1, "R6", "R10", "R10");

        // Seeded random phase.
        for (int i = 0; i < 3000; i++) begin
            logic wr, slp, wdt, wk;
            logic [7:0] d;
            wr  = ($urandom % 4) == 0;
            d   = 8'($urandom);
            slp = ($urandom % 6) == 0;
            wdt = ($urandom % 2) == 0;
            wk  = ($urandom % 8) == 0;
            step(wr, d, slp, wdt, wk, "R2 R3 R4 R5 R6 rand", "R7 R8 R10 R11 R12 rand", "R9 R10 rand");
        end
        finish_run();
    end
endmodule